// File: doc/BRIEF.md
# I2C Serial Clock Tick Generator

This block derives the serial clock timing of an I2C master from the system clock. It reads a 4-bit mode field and an 8-bit divider value. From them it produces two one-cycle ticks: one marks the start of the SCL high half and one marks the start of the SCL low half. It also gives a level that shows which half is in progress. A bit-level engine uses these ticks to move SDA and SCL.

The half-period length is `P × (D + 3 + 2F)` system clock cycles. P is a power-of-two predivider (32, 16, 8 or 4), D is the 8-bit divider and F is the filter bit. A full SCL period is twice that length. The controller moves through three named states:

- `ST_IDLE`: waiting, with all counters held at zero.
- `ST_LOW`: counting the low half.
- `ST_HIGH`: counting the high half.

The transitions are:

- enable sampled 1 in `ST_IDLE`: go to `ST_LOW`.
- half done in `ST_LOW`: go to `ST_HIGH` and issue the rise tick.
- half done in `ST_HIGH`: go to `ST_LOW` and issue the fall tick.
- enable sampled 0 in either counting state: go to `ST_IDLE`.

The settings are captured when generation starts and again at each fall tick. A write between those points therefore never shortens a period.

Top module: `scl_tick_gen`

## Requirements
- R1: After reset, `tick_rise`, `tick_fall` and `scl_level` are all 0.
- R2: `mode_bits[2:1]` selects the predivider P. Code 0 gives 32, code 1 gives 16, code 2 gives 8 and code 3 gives 4.
- R3: Each half of the SCL period lasts H = P × (D + 3 + 2F) cycles. D is `div_val` and F is `mode_bits[3]`. The rise tick and the next fall tick are H cycles apart, and so are a fall tick and the next rise tick.
- R4: Setting the filter bit `mode_bits[3]` to 1 adds 2 × P cycles to each half.
- R5: `mode_bits[0]` is the enable. In the cycle after enable is sampled 0, the block is idle: no tick is produced and `scl_level` is 0. It stays idle until enable returns to 1.
- R6: Sample enable as 1 at a clock edge while the block is idle. The first `tick_rise` then appears H cycles after that edge, which is a full low half. This holds even if generation was stopped partway through a half.
- R7: Both ticks last exactly one cycle and are never asserted together. `scl_level` is 1 from the rise tick up to the fall tick and 0 otherwise.
- R8: A change to D, P or F while generation runs has no effect before the next fall tick. It sets the length of both halves that follow that tick.
- R9: The divider extremes D = 0 and D = 255 both give the length stated in R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_bits | input | 4 | Bit 0 enable, bits 2:1 predivider code, bit 3 filter |
| div_val | input | 8 | Divider value D, 0 to 255 |
| tick_rise | output | 1 | One-cycle pulse at the start of the SCL high half |
| tick_fall | output | 1 | One-cycle pulse at the start of the SCL low half |
| scl_level | output | 1 | 1 during the high half, 0 during the low half and while idle |

## Verification
The bench measures the gap between ticks for every predivider code, with the filter bit set and clear, and at both divider extremes. A wrong code mapping or a missing filter term would show up as an exact cycle-count mismatch. The bench rewrites the divider right after a rise tick. A design that loaded settings at once would produce a shortened or stretched high half instead of the old length followed by the new one. The bench also stops generation in the middle of a half and restarts it. A design that kept stale counts, or went on ticking after the stop, would give a short first half or stray ticks.

// File: rtl/scl_tick_pkg.sv
package scl_tick_pkg;

    localparam int PRE_CODE_W = 2;
    localparam int PRE_LOG    = 5;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOW  = 2'd1,
        ST_HIGH = 2'd2
    } phase_e;

    // last count value of the predivider: 31, 15, 7 or 3
    function automatic logic [PRE_LOG-1:0] pre_last(input logic [PRE_CODE_W-1:0] code);
        return {PRE_LOG{1'b1}} >> code;
    endfunction

endpackage

// File: rtl/scl_prescale.sv
module scl_prescale
    import scl_tick_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr,
    input  logic [PRE_CODE_W-1:0] code,
    output logic                  strobe
);
    logic [PRE_LOG-1:0] cnt_q;
    logic [PRE_LOG-1:0] last;

    assign last   = pre_last(code);
    assign strobe = !clr && (cnt_q == last);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clr || strobe)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    // R2: the predivider count never exceeds the selected ratio
    a_r2_pre_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= last);

endmodule

// File: rtl/scl_half_count.sv
module scl_half_count #(
    parameter int LIM_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             step,
    input  logic [LIM_W-1:0] limit,
    output logic             done
);
    logic [LIM_W-1:0] cnt_q;

    assign done = step && (cnt_q == limit - 1'b1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clr || done)
            cnt_q <= '0;
        else if (step)
            cnt_q <= cnt_q + 1'b1;
    end

    // R3: the step count stays below the active term
    a_r3_half_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < limit);

endmodule

// File: rtl/scl_tick_gen.sv
module scl_tick_gen
    import scl_tick_pkg::*;
#(
    parameter int DIV_W  = 8,
    parameter int MODE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode_bits,
    input  logic [DIV_W-1:0]  div_val,
    output logic              tick_rise,
    output logic              tick_fall,
    output logic              scl_level
);
    localparam int LIM_W = DIV_W + 1;

    phase_e state_q, state_d;

    logic                  en;
    logic                  load;
    logic                  clr;
    logic                  strobe;
    logic                  done;
    logic [DIV_W-1:0]      cfg_div_q;
    logic [PRE_CODE_W-1:0] cfg_code_q;
    logic                  cfg_filt_q;
    logic [LIM_W-1:0]      limit;

    assign en    = mode_bits[0];
    assign clr   = (state_q == ST_IDLE) || !en;
    assign limit = {1'b0, cfg_div_q} + LIM_W'(3) + {{(LIM_W-2){1'b0}}, cfg_filt_q, 1'b0};
    assign load  = en && ((state_q == ST_IDLE) || (state_q == ST_HIGH && done));

    scl_prescale u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (clr),
        .code   (cfg_code_q),
        .strobe (strobe)
    );

    scl_half_count #(.LIM_W(LIM_W)) u_half (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .step  (strobe),
        .limit (limit),
        .done  (done)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (en) state_d = ST_LOW;
            ST_LOW:  if (!en) state_d = ST_IDLE;
                     else if (done) state_d = ST_HIGH;
            ST_HIGH: if (!en) state_d = ST_IDLE;
                     else if (done) state_d = ST_LOW;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick_rise  <= 1'b0;
            tick_fall  <= 1'b0;
            cfg_div_q  <= '0;
            cfg_code_q <= '0;
            cfg_filt_q <= 1'b0;
        end else begin
            tick_rise <= en && (state_q == ST_LOW) && done;
            tick_fall <= en && (state_q == ST_HIGH) && done;
            if (load) begin
                cfg_div_q  <= div_val;
                cfg_code_q <= mode_bits[2:1];
                cfg_filt_q <= mode_bits[3];
            end
        end
    end

    assign scl_level = (state_q == ST_HIGH);

    // R7: ticks never coincide
    a_r7_tick_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(tick_rise && tick_fall));

    // R7: a rise tick lasts one cycle
    a_r7_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
        tick_rise |=> !tick_rise);

    // R7: the high level accompanies the rise tick
    a_r7_rise_level: assert property (@(posedge clk) disable iff (!rst_n)
        tick_rise |-> scl_level);

    // R5: a cleared enable silences the outputs on the next cycle
    a_r5_stop: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!tick_rise && !tick_fall && !scl_level));

    // R8: the active settings hold while the high half runs
    a_r8_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_level && en && !done) |=> $stable(cfg_div_q));

endmodule

// File: tb/scl_tick_gen_test.sv
`timescale 1ns/1ps
module scl_tick_gen_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] mode_bits = 4'd0;
    logic [7:0] div_val = 8'd0;
    logic       tick_rise, tick_fall, scl_level;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    scl_tick_gen uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_bits (mode_bits),
        .div_val   (div_val),
        .tick_rise (tick_rise),
        .tick_fall (tick_fall),
        .scl_level (scl_level)
    );

    function automatic int half_len(input int code, input int filt, input int d);
        return (32 >> code) * (d + 3 + 2 * filt);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // counts falling edges until the chosen tick is seen
    task automatic wait_tick(input bit rise, input int lim, output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (((rise ? tick_rise : tick_fall) == 1'b0) && n < lim);
    endtask

    task automatic start_gen(input int code, input int filt, input int d);
        @(negedge clk);
        mode_bits = {filt[0], code[1:0], 1'b0};
        div_val   = d[7:0];
        repeat (2) @(negedge clk);
        mode_bits[0] = 1'b1;
    endtask

    task automatic run_one(input int code, input int filt, input int d, input string req);
        int n, h;
        h = half_len(code, filt, d);
        start_gen(code, filt, d);
        wait_tick(1'b1, h + 10, n);
        check(n == h + 1, {req, " first low half"}, n, h + 1);
        @(negedge clk);
        check(!tick_rise && scl_level, "R7 rise tick width", int'(tick_rise), 0);
        wait_tick(1'b0, h + 10, n);
        check(n == h - 1, {req, " high half"}, n + 1, h);
        check(!scl_level, "R7 level after fall", int'(scl_level), 0);
        wait_tick(1'b1, h + 10, n);
        check(n == h, {req, " second low half"}, n, h);
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        check(!tick_rise && !tick_fall && !scl_level, "R1 reset outputs",
              int'({tick_rise, tick_fall, scl_level}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(!tick_rise && !tick_fall && !scl_level, "R1 idle after reset",
              int'({tick_rise, tick_fall, scl_level}), 0);
    endtask

    task automatic t_codes;
        for (int c = 0; c < 4; c++) run_one(c, 0, 10, "R2 R3");
    endtask

    task automatic t_filter;
        run_one(1, 1, 10, "R4");
        run_one(3, 1, 0, "R4");
    endtask

    task automatic t_extremes;
        run_one(3, 0, 0, "R9 div zero");
        run_one(0, 1, 255, "R9 div max");
    endtask

    task automatic t_deferred;
        int n;
        int h_old, h_new;
        h_old = half_len(3, 0, 5);
        h_new = half_len(3, 0, 9);
        start_gen(3, 0, 5);
        wait_tick(1'b1, h_old + 10, n);
        div_val = 8'd9;
        wait_tick(1'b0, h_old + 10, n);
        check(n == h_old, "R8 high half keeps old setting", n, h_old);
        wait_tick(1'b1, h_new + 10, n);
        check(n == h_new, "R8 low half uses new setting", n, h_new);
        wait_tick(1'b0, h_new + 10, n);
        check(n == h_new, "R8 high half uses new setting", n, h_new);
    endtask

    task automatic t_stop_restart;
        int n, h, seen;
        h = half_len(3, 0, 4);
        start_gen(3, 0, 4);
        repeat (h / 2) @(negedge clk);
        mode_bits[0] = 1'b0;
        seen = 0;
        for (int i = 0; i < 3 * h; i++) begin
            @(negedge clk);
            if (tick_rise || tick_fall || scl_level) seen++;
        end
        check(seen == 0, "R5 no activity while disabled", seen, 0);
        wait_tick(1'b1, 5, n);
        check(n == 5 && !tick_rise, "R5 no rise while disabled", int'(tick_rise), 0);
        mode_bits[0] = 1'b1;
        wait_tick(1'b1, h + 10, n);
        check(n == h + 1, "R6 full first half after restart", n, h + 1);
        @(negedge clk);
        mode_bits[0] = 1'b0;
    endtask

    initial begin
        t_reset();
        t_codes();
        t_filter();
        t_extremes();
        t_deferred();
        t_stop_restart();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule